// File: doc/BRIEF.md
# Gated Pulse-Counting Frequency ADC

This block converts a pulse train, whose average rate is proportional to an analog quantity, into a digital code. It counts the rising edges of the pulse train over a fixed gate window. The window is measured by a binary divider that runs from the same master clock that also clocks the upstream voltage-to-frequency stage. Any drift in that clock changes the pulse rate and the gate length by the same factor, so the drift cancels in the result.

A conversion begins when `start_i` is sampled high while the block is idle. The gate then stays open for exactly 2^GATE_LOG2 master clock cycles. The asynchronous pulse input passes through a two-flop synchronizer and an edge detector before it reaches the counter. When the gate closes, the block latches the raw count and raises `done_o` for one cycle.

A second output gives the count with the zero-scale offset removed. The upstream converter emits 5% of the clock rate at zero input, so the block subtracts that fixed number of counts from the raw count and floors the result at zero. The gate length can be set at elaboration. Choosing a gate that spans a whole number of periods of an interfering signal rejects that interference.

Top module: `freq_gate_adc`

## Requirements
- R1: While reset is asserted, and after reset until the first conversion ends, `done_o` is 0 and `raw_count_o` and `code_o` are 0.
- R2: When `start_i` is sampled high at a clock edge while idle, the gate opens for exactly 2^GATE_LOG2 cycles. `done_o` is high in the cycle that follows the 2^GATE_LOG2-th clock edge after the edge that sampled `start_i`.
- R3: Only rising edges of `pulse_i` are counted, after two synchronizing flops. A level held high from before the gate opens adds no counts.
- R4: For a pulse train with an average of r pulses per 100 clocks, `raw_count_o` is within one count of 2^GATE_LOG2·r/100.
- R5: `raw_count_o` and `code_o` hold their values from one `done_o` pulse to the next, whatever `pulse_i` does in between.
- R6: `code_o` equals `raw_count_o` minus floor(2^GATE_LOG2·5/100), which is 204 for the default GATE_LOG2 of 12. When that difference would be negative, `code_o` is 0.
- R7: A `start_i` that arrives while the gate is open is ignored. It neither restarts nor lengthens the window.
- R8: The edge counter is cleared when a gate opens, so each result depends only on its own window.
- R9: `done_o` lasts exactly one cycle per conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock, shared with the upstream converter |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously |
| start_i | input | 1 | Conversion request; takes effect only while idle |
| pulse_i | input | 1 | Asynchronous pulse train to be counted |
| raw_count_o | output | GATE_LOG2+1 | Rising-edge count latched at the end of the gate |
| code_o | output | GATE_LOG2+1 | Raw count minus the zero-scale offset, floored at 0 |
| done_o | output | 1 | One-cycle strobe marking a new result |

## Verification
Both results and the strobe become due together, in the cycle after the 2^GATE_LOG2-th rising edge that follows the edge which sampled `start_i`. The bench counts rising edges from that sampling edge and reads `done_o`, `raw_count_o` and `code_o` on the falling edge that follows. This way the expected cycle number is compared exactly rather than by polling loosely. The bench checks the count against the programmed rate with a tolerance of one count, because the gate and the synchronizer delay are not aligned to the pulse phase. It checks the corrected code exactly against the raw count it reads. It samples the strobe again one falling edge later to confirm that the strobe has dropped.

// File: rtl/fgadc_pkg.sv
package fgadc_pkg;

  typedef enum logic {
    PH_IDLE = 1'b0,
    PH_GATE = 1'b1
  } phase_e;

  // Counts produced at zero scale (5 % of the clock rate) over 2^log2 cycles.
  function automatic int unsigned zero_scale_counts(input int unsigned log2);
    return ((32'd1 << log2) * 32'd5) / 32'd100;
  endfunction

endpackage

// File: rtl/fgadc_pulse_sync.sv
module fgadc_pulse_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic rise_o
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;
  logic              prev_q;
  logic              prev_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], async_i};
    prev_d = sync_q[STAGES-1];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      prev_q <= prev_d;
    end
  end

  assign rise_o = sync_q[STAGES-1] & ~prev_q;

  AST_RISE_ISOLATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o); // R3

endmodule

// File: rtl/fgadc_gate_timer.sv
module fgadc_gate_timer #(
  parameter int GATE_LOG2 = 12
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic open_o,
  output logic gate_o,
  output logic last_o
);
  import fgadc_pkg::*;

  localparam logic [GATE_LOG2-1:0] DIV_LAST = '1;

  phase_e               phase_q, phase_d;
  logic [GATE_LOG2-1:0] div_q, div_d;
  logic                 div_en;

  assign open_o = (phase_q == PH_IDLE) && start_i;
  assign gate_o = (phase_q == PH_GATE);
  assign last_o = gate_o && (div_q == DIV_LAST);

  always_comb begin
    phase_d = phase_q;
    div_d   = div_q;
    div_en  = 1'b0;
    if (open_o) begin
      phase_d = PH_GATE;
      div_d   = '0;
      div_en  = 1'b1;
    end else if (gate_o) begin
      div_d  = div_q + GATE_LOG2'(1);
      div_en = 1'b1;
      if (last_o) phase_d = PH_IDLE;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) phase_q <= PH_IDLE;
    else         phase_q <= phase_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     div_q <= '0;
    else if (div_en) div_q <= div_d;
  end

  AST_GATE_CLOSES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o |=> !gate_o); // R2
  AST_START_NO_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gate_o && !last_o && start_i) |=> (gate_o && div_q == $past(div_q) + GATE_LOG2'(1))); // R7

endmodule

// File: rtl/fgadc_edge_counter.sv
module fgadc_edge_counter #(
  parameter int CNT_W = 13
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             count_en_i,
  input  logic             rise_i,
  output logic [CNT_W-1:0] total_o
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  // Count including an edge seen in the current cycle.
  assign total_o = cnt_q + CNT_W'(count_en_i & rise_i);

  always_comb begin
    cnt_en = clear_i | (count_en_i & rise_i);
    cnt_d  = clear_i ? '0 : total_o;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  AST_CLEAR_ON_OPEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (cnt_q == '0)); // R8

endmodule

// File: rtl/freq_gate_adc.sv
module freq_gate_adc #(
  parameter int GATE_LOG2 = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 start_i,
  input  logic                 pulse_i,
  output logic [GATE_LOG2:0]   raw_count_o,
  output logic [GATE_LOG2:0]   code_o,
  output logic                 done_o
);
  import fgadc_pkg::*;

  localparam int CNT_W = GATE_LOG2 + 1;
  localparam logic [CNT_W-1:0] ZERO_OFS = CNT_W'(zero_scale_counts(GATE_LOG2));

  logic             rise;
  logic             gate_open, gate_on, gate_last;
  logic [CNT_W-1:0] total;
  logic [CNT_W-1:0] raw_q, raw_d;
  logic             raw_en;
  logic             done_q, done_d;

  fgadc_pulse_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i (pulse_i),
    .rise_o  (rise)
  );

  fgadc_gate_timer #(.GATE_LOG2(GATE_LOG2)) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .open_o  (gate_open),
    .gate_o  (gate_on),
    .last_o  (gate_last)
  );

  fgadc_edge_counter #(.CNT_W(CNT_W)) u_count (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clear_i    (gate_open),
    .count_en_i (gate_on),
    .rise_i     (rise),
    .total_o    (total)
  );

  always_comb begin
    raw_en = gate_last;
    raw_d  = total;
    done_d = gate_last;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     raw_q <= '0;
    else if (raw_en) raw_q <= raw_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) done_q <= 1'b0;
    else         done_q <= done_d;
  end

  assign raw_count_o = raw_q;
  assign done_o      = done_q;
  assign code_o      = (raw_q > ZERO_OFS) ? (raw_q - ZERO_OFS) : '0;

  AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R9
  AST_RESULT_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(raw_count_o)); // R5
  AST_CODE_FLOOR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    code_o <= raw_count_o); // R6

endmodule

// File: tb/test_freq_gate_adc.sv
module test_freq_gate_adc;

  localparam time CLK_PERIOD = 10ns;
  localparam int  K          = 12;
  localparam int  GATE       = 1 << K;
  localparam int  OFS        = (GATE * 5) / 100;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         start_i = 1'b0;
  logic         pulse_i = 1'b0;
  logic [K:0]   raw_count_o;
  logic [K:0]   code_o;
  logic         done_o;

  int total = 0;
  int bad   = 0;

  int gen_rate = 0;
  bit gen_hold = 1'b0;
  int gen_acc  = 0;

  freq_gate_adc #(.GATE_LOG2(K)) i_freq_gate_adc (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .pulse_i     (pulse_i),
    .raw_count_o (raw_count_o),
    .code_o      (code_o),
    .done_o      (done_o)
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  // Pulse source: r pulses per 100 clocks, each one clock high.
  initial begin
    forever begin
      @(negedge clk_i);
      if (gen_hold) pulse_i = 1'b1;
      else begin
        gen_acc = gen_acc + gen_rate;
        if (gen_acc >= 100) begin
          gen_acc = gen_acc - 100;
          pulse_i = 1'b1;
        end else pulse_i = 1'b0;
      end
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int expect_code(input int raw);
    return (raw > OFS) ? raw - OFS : 0;
  endfunction

  // Runs one conversion; returns edges counted from the start-sampling edge.
  task automatic convert(input int mid_start, output int raw, output int code,
                         output int edges);
    @(negedge clk_i);
    start_i = 1'b1;
    @(posedge clk_i);
    @(negedge clk_i);
    start_i = 1'b0;
    edges = 0;
    forever begin
      @(posedge clk_i);
      edges++;
      @(negedge clk_i);
      if (mid_start != 0 && edges == mid_start)     start_i = 1'b1;
      if (mid_start != 0 && edges == mid_start + 1) start_i = 1'b0;
      if (done_o || edges > GATE + 8) break;
    end
    raw  = int'(raw_count_o);
    code = int'(code_o);
    @(posedge clk_i);
    @(negedge clk_i);
    check(done_o == 1'b0, "R9", "done strobe width", int'(done_o), 0);
  endtask

  task automatic t_reset();
    check(done_o == 1'b0, "R1", "done after reset", int'(done_o), 0);
    check(raw_count_o == '0, "R1", "raw after reset", int'(raw_count_o), 0);
    check(code_o == '0, "R1", "code after reset", int'(code_o), 0);
  endtask

  task automatic t_rate(input int r, input string tag);
    int raw, code, edges, dev;
    gen_hold = 1'b0;
    gen_rate = r;
    repeat (20) @(negedge clk_i);
    convert(0, raw, code, edges);
    check(edges == GATE, "R2", "done cycle", edges, GATE);
    dev = raw * 100 - GATE * r;
    if (dev < 0) dev = -dev;
    check(dev <= 100, {"R4 ", tag}, "raw count", raw, (GATE * r) / 100);
    check(code == expect_code(raw), "R6", "corrected code", code, expect_code(raw));
  endtask

  task automatic t_silent();
    int raw, code, edges;
    gen_hold = 1'b0;
    gen_rate = 0;
    repeat (10) @(negedge clk_i);
    convert(0, raw, code, edges);
    check(raw == 0, "R4", "raw with no pulses", raw, 0);
    check(code == 0, "R6", "code floored at zero", code, 0);
  endtask

  task automatic t_hold_high();
    int raw, code, edges;
    gen_rate = 0;
    gen_hold = 1'b1;
    repeat (10) @(negedge clk_i);
    convert(0, raw, code, edges);
    check(raw == 0, "R3", "steady high level", raw, 0);
    gen_hold = 1'b0;
  endtask

  task automatic t_start_mid_gate();
    int raw, code, edges;
    gen_hold = 1'b0;
    gen_rate = 10;
    repeat (10) @(negedge clk_i);
    convert(GATE / 3, raw, code, edges);
    check(edges == GATE, "R7", "window length with extra start", edges, GATE);
    repeat (200) begin
      @(negedge clk_i);
      if (done_o) break;
    end
    check(done_o == 1'b0, "R7", "no second result", int'(done_o), 0);
  endtask

  task automatic t_hold_result();
    int raw, code, edges;
    gen_hold = 1'b0;
    gen_rate = 30;
    repeat (10) @(negedge clk_i);
    convert(0, raw, code, edges);
    gen_rate = 45;
    repeat (300) @(negedge clk_i);
    check(int'(raw_count_o) == raw, "R5", "raw held", int'(raw_count_o), raw);
    check(int'(code_o) == code, "R5", "code held", int'(code_o), code);
    check(done_o == 1'b0, "R5", "no strobe while idle", int'(done_o), 0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    bad++;
    total++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    repeat (3) @(negedge clk_i);
    t_reset();
    t_rate(45, "full scale");
    t_rate(5, "zero scale");
    t_rate(25, "mid scale R8");
    t_rate(12, "low rate");
    t_silent();
    t_hold_high();
    t_start_mid_gate();
    t_hold_result();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule